// File: doc/BRIEF.md
# Harris Corner Response with Threshold Filter

This block sits after a gradient stage in an image feature pipeline. Each cycle it can accept one pixel in raster order. A pixel carries its signed horizontal and vertical gradients, its column and row, and markers for the first and last pixel of a frame. From the gradients it forms three products: the squared horizontal gradient, the squared vertical gradient and the cross product. It sums each product over a 3x3 window and computes the corner response R from the windowed sums. It then emits only those window centres whose response is strictly above a threshold.

All values are signed fixed point with 15 fraction bits and 28 integer bits, 43 bits in total. Every stage after the multipliers truncates to that format and saturates instead of wrapping. The threshold is taken once per frame, when the frame's first pixel arrives. The block counts the features it accepts in each frame and reports the total with a one-cycle strobe when the frame's last pixel leaves the pipeline.

Top module: `harris_corner`

## Requirements
- R1: Each product is (a*b) shifted right arithmetically by 15 bits, where a and b are the gradients taken as values with 15 fraction bits. Channel 0 is gx*gx, channel 1 is gy*gy and channel 2 is gx*gy.
- R2: A pixel accepted at column x >= 2 and row y >= 2 completes the 3x3 window over columns x-2..x and rows y-2..y. Each column of three products is summed and saturated, then the three column sums are added and saturated. The feature reports the window centre (x-1, y-1). No other pixel produces a feature.
- R3: The response is R = D - ((T >>> 5) + (T >>> 7)), which applies k = 5/128 to T. D = sat(fix(Sxx*Syy) - fix(Sxy*Sxy)), T = fix(tr*tr) and tr = sat(Sxx+Syy). Here fix() is the R1 multiply.
- R4: Every intermediate value and R saturate to the range -2^42 .. 2^42-1 instead of wrapping.
- R5: A feature is emitted only when R is strictly greater than the frame's threshold, compared as signed 43-bit values. A threshold equal to R rejects the pixel.
- R6: The feature appears with outValid high, carrying the centre coordinates and R. It appears six clock edges after the edge that sampled the completing pixel.
- R7: The threshold input is sampled with the first pixel of a frame (inSof) and holds for that whole frame. Later changes take effect only from the next frame.
- R8: The accepted-feature count restarts at every frame start. frameDone pulses for one cycle, with frameCount equal to the frame's total, on the same cycle the last pixel's feature would appear.
- R9: A cycle with inValid low changes no state, whatever the other inputs carry, including the inSof and inEof markers.
- R10: After reset, outValid and frameDone are low until the first frame's results arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Pixel present this cycle |
| inSof | input | 1 | First pixel of a frame |
| inEof | input | 1 | Last pixel of a frame |
| inX | input | COORD_W | Pixel column |
| inY | input | COORD_W | Pixel row |
| inGx | input | GRAD_W | Signed horizontal gradient, 15 fraction bits |
| inGy | input | GRAD_W | Signed vertical gradient, 15 fraction bits |
| threshold | input | 43 | Signed response threshold, sampled at frame start |
| outValid | output | 1 | Accepted feature present |
| outX | output | COORD_W | Feature centre column |
| outY | output | COORD_W | Feature centre row |
| outR | output | 43 | Feature response |
| frameDone | output | 1 | One-cycle end-of-frame strobe |
| frameCount | output | CNT_W | Features accepted in the finished frame |

## Verification
The embedded checks assume the following about the input:
- Pixels arrive in strict raster order.
- Every row is exactly IMG_W pixels wide.
- The coordinates match the pixel's position.
- A frame holds at least two rows, so two inEof markers are never adjacent and two frame starts are many cycles apart.

The stimulus keeps within these limits by always driving complete 8x6 rasters, with idle cycles placed only between pixels. Those idle cycles deliberately raise inSof and inEof and carry random gradients and coordinates. The gradients cover three ranges: small random values, full-range values that drive the window sums and the response into saturation, and constants that fix R exactly, which pins down the strict threshold comparison.

// File: rtl/harris_pkg.sv
package harris_pkg;
  localparam int FRAC_W = 15;
  localparam int INT_W  = 28;
  localparam int VAL_W  = INT_W + FRAC_W;
  localparam int WIDE_W = 2 * VAL_W + 4;

  typedef logic signed [VAL_W-1:0]  val_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam val_t VAL_MAX = {1'b0, {(VAL_W-1){1'b1}}};
  localparam val_t VAL_MIN = {1'b1, {(VAL_W-1){1'b0}}};

  // strobes from control to datapath
  typedef struct packed {
    logic lbWrite;   // stage-1 pixel valid: update line stores
    logic colShift;  // stage-2 pixel valid: advance column history
  } dpStrobe_t;

  function automatic val_t satVal(wide_t v);
    if (v > wide_t'(VAL_MAX)) return VAL_MAX;
    if (v < wide_t'(VAL_MIN)) return VAL_MIN;
    return val_t'(v);
  endfunction

  function automatic val_t fixMul(val_t a, val_t b);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    return satVal(p >>> FRAC_W);
  endfunction
endpackage

// File: rtl/harris_dp.sv
module harris_dp import harris_pkg::*; #(
  parameter int IMG_W  = 64,
  parameter int GRAD_W = 29,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GRAD_W-1:0] inGx,
  input  logic [GRAD_W-1:0] inGy,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] lbAddr,
  output val_t              rOut
);
  val_t gxV, gyV;
  assign gxV = val_t'($signed(inGx));
  assign gyV = val_t'($signed(inGy));

  for (genvar c = 0; c < 3; c++) begin : chan
    val_t opA, opB;
    val_t prodQ, colQ, boxQ, hist1, hist2;
    val_t lineA [IMG_W];
    val_t lineB [IMG_W];

    assign opA = (c == 1) ? gyV : gxV;
    assign opB = (c == 0) ? gxV : gyV;

    always_ff @(posedge clk) begin
      if (rst) begin
        prodQ <= '0; colQ <= '0; boxQ <= '0; hist1 <= '0; hist2 <= '0;
      end else begin
        prodQ <= fixMul(opA, opB);
        colQ  <= satVal(wide_t'(prodQ) + wide_t'(lineA[lbAddr]) + wide_t'(lineB[lbAddr]));
        boxQ  <= satVal(wide_t'(colQ) + wide_t'(hist1) + wide_t'(hist2));
        if (strobe.colShift) begin
          hist1 <= colQ;
          hist2 <= hist1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.lbWrite) begin
        lineB[lbAddr] <= lineA[lbAddr];
        lineA[lbAddr] <= prodQ;
      end
    end
  end

  val_t detA, detB, traceQ, detQ, trSq, rQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      detA <= '0; detB <= '0; traceQ <= '0; detQ <= '0; trSq <= '0; rQ <= '0;
    end else begin
      detA   <= fixMul(chan[0].boxQ, chan[1].boxQ);
      detB   <= fixMul(chan[2].boxQ, chan[2].boxQ);
      traceQ <= satVal(wide_t'(chan[0].boxQ) + wide_t'(chan[1].boxQ));
      detQ   <= satVal(wide_t'(detA) - wide_t'(detB));
      trSq   <= fixMul(traceQ, traceQ);
      rQ     <= satVal(wide_t'(detQ) - (wide_t'(trSq >>> 5) + wide_t'(trSq >>> 7)));
    end
  end

  assign rOut = rQ;

  // R3
  trsq_nonneg_chk: assert property (@(posedge clk) disable iff (rst) !trSq[VAL_W-1]);

  // R4
  r_below_det_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (rQ <= $past(detQ)));
endmodule

// File: rtl/harris_ctrl.sv
module harris_ctrl import harris_pkg::*; #(
  parameter int IMG_W   = 64,
  parameter int COORD_W = 12,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic               inSof,
  input  logic               inEof,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  val_t               threshold,
  input  val_t               rIn,
  output dpStrobe_t          strobe,
  output logic [ADDR_W-1:0]  lbAddr,
  output logic               outValid,
  output logic [COORD_W-1:0] outX,
  output logic [COORD_W-1:0] outY,
  output val_t               outR,
  output logic               frameDone,
  output logic [CNT_W-1:0]   frameCount
);
  localparam int DEPTH = 6;

  logic [DEPTH:1] vP, sofP, eofP, keepP;
  logic [COORD_W-1:0] xP [1:DEPTH];
  logic [COORD_W-1:0] yP [1:DEPTH];
  logic inKeep;

  assign inKeep = inValid && (inX >= COORD_W'(2)) && (inY >= COORD_W'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      vP <= '0; sofP <= '0; eofP <= '0; keepP <= '0;
    end else begin
      vP    <= {vP[DEPTH-1:1], inValid};
      sofP  <= {sofP[DEPTH-1:1], inValid && inSof};
      eofP  <= {eofP[DEPTH-1:1], inValid && inEof};
      keepP <= {keepP[DEPTH-1:1], inKeep};
    end
  end

  always_ff @(posedge clk) begin
    xP[1] <= inX;
    yP[1] <= inY;
    for (int i = 2; i <= DEPTH; i++) begin
      xP[i] <= xP[i-1];
      yP[i] <= yP[i-1];
    end
  end

  assign strobe.lbWrite  = vP[1];
  assign strobe.colShift = vP[2];
  assign lbAddr = xP[1][ADDR_W-1:0];

  val_t thPending, thActive, thCur;
  logic frameStart, accept;
  logic [CNT_W-1:0] cnt, cntBase, cntNext;

  assign frameStart = vP[DEPTH] && sofP[DEPTH];
  assign thCur   = frameStart ? thPending : thActive;
  assign accept  = vP[DEPTH] && keepP[DEPTH] && (rIn > thCur);
  assign cntBase = frameStart ? '0 : cnt;
  assign cntNext = cntBase + CNT_W'(accept);

  always_ff @(posedge clk) begin
    if (rst) begin
      thPending <= '0; thActive <= '0; cnt <= '0;
      outValid <= 1'b0; frameDone <= 1'b0; frameCount <= '0;
      outX <= '0; outY <= '0; outR <= '0;
    end else begin
      if (inValid && inSof) thPending <= threshold;
      if (frameStart) thActive <= thPending;
      if (vP[DEPTH]) cnt <= cntNext;
      outValid  <= accept;
      outX      <= xP[DEPTH] - COORD_W'(1);
      outY      <= yP[DEPTH] - COORD_W'(1);
      outR      <= rIn;
      frameDone <= vP[DEPTH] && eofP[DEPTH];
      if (vP[DEPTH] && eofP[DEPTH]) frameCount <= cntNext;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) frameDone |=> !frameDone);

  // R2
  centre_range_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outX >= COORD_W'(1)) && (outX <= COORD_W'(IMG_W-2)) && (outY >= COORD_W'(1)));

  // R7
  th_hold_chk: assert property (@(posedge clk) disable iff (rst) !frameStart |=> $stable(thActive));

  // R5
  accept_gap_chk: assert property (@(posedge clk) disable iff (rst) !vP[DEPTH] |=> !outValid);
endmodule

// File: rtl/harris_corner.sv
module harris_corner import harris_pkg::*; #(
  parameter int IMG_W   = 64,
  parameter int GRAD_W  = 29,
  parameter int COORD_W = 12,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     inSof,
  input  logic                     inEof,
  input  logic [COORD_W-1:0]       inX,
  input  logic [COORD_W-1:0]       inY,
  input  logic signed [GRAD_W-1:0] inGx,
  input  logic signed [GRAD_W-1:0] inGy,
  input  logic signed [VAL_W-1:0]  threshold,
  output logic                     outValid,
  output logic [COORD_W-1:0]       outX,
  output logic [COORD_W-1:0]       outY,
  output logic signed [VAL_W-1:0]  outR,
  output logic                     frameDone,
  output logic [CNT_W-1:0]         frameCount
);
  localparam int ADDR_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;

  dpStrobe_t strobe;
  logic [ADDR_W-1:0] lbAddr;
  val_t rVal;

  harris_ctrl #(.IMG_W(IMG_W), .COORD_W(COORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inX(inX), .inY(inY), .threshold(threshold), .rIn(rVal),
    .strobe(strobe), .lbAddr(lbAddr), .outValid(outValid), .outX(outX), .outY(outY),
    .outR(outR), .frameDone(frameDone), .frameCount(frameCount)
  );

  harris_dp #(.IMG_W(IMG_W), .GRAD_W(GRAD_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .inGx(inGx), .inGy(inGy),
    .strobe(strobe), .lbAddr(lbAddr), .rOut(rVal)
  );
endmodule

// File: tb/sim_harris_corner.sv
module sim_harris_corner;
  localparam int W = 8;
  localparam int H = 6;
  localparam int CW = 12;
  localparam int NW = 16;
  localparam int GW = 29;

  typedef logic signed [127:0] big_t;
  typedef struct { int due; int x; int y; big_t r; } feat_t;
  typedef struct { int due; int n; } done_t;

  logic clk = 1'b0, rst = 1'b1;
  logic inValid = 0, inSof = 0, inEof = 0;
  logic [CW-1:0] inX = '0, inY = '0;
  logic signed [GW-1:0] inGx = '0, inGy = '0;
  logic signed [42:0] threshold = '0;
  logic outValid, frameDone;
  logic [CW-1:0] outX, outY;
  logic signed [42:0] outR;
  logic [NW-1:0] frameCount;

  harris_corner #(.IMG_W(W), .GRAD_W(GW), .COORD_W(CW), .CNT_W(NW)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inX(inX), .inY(inY), .inGx(inGx), .inGy(inGy), .threshold(threshold),
    .outValid(outValid), .outX(outX), .outY(outY), .outR(outR),
    .frameDone(frameDone), .frameCount(frameCount));

  always #5 clk = ~clk;

  int edgeCnt = 0, checks = 0, fails = 0;
  feat_t expQ[$];
  done_t doneQ[$];
  longint gxA [H][W];
  longint gyA [H][W];
  big_t frameTh;
  int frameN;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  always @(posedge clk) if (edgeCnt == 20000) begin
    fails++;
    $display("FAIL watchdog expired: actual running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic big_t sat(big_t v);
    big_t mx = (big_t'(1) <<< 42) - 1;
    big_t mn = -(big_t'(1) <<< 42);
    if (v > mx) return mx;
    if (v < mn) return mn;
    return v;
  endfunction

  function automatic big_t fmul(big_t a, big_t b);
    return sat((a * b) >>> 15);
  endfunction

  function automatic big_t pr(int ch, int yy, int xx);
    big_t a, b;
    a = (ch == 1) ? big_t'(gyA[yy][xx]) : big_t'(gxA[yy][xx]);
    b = (ch == 0) ? big_t'(gxA[yy][xx]) : big_t'(gyA[yy][xx]);
    return fmul(a, b);
  endfunction

  function automatic big_t modelR(int x, int y);
    big_t s[3];
    big_t a, b, tr, det, t2;
    for (int ch = 0; ch < 3; ch++) begin
      big_t box = 0;
      for (int dx = 0; dx < 3; dx++)
        box += sat(pr(ch, y-2, x-dx) + pr(ch, y-1, x-dx) + pr(ch, y, x-dx));
      s[ch] = sat(box);
    end
    a = fmul(s[0], s[1]);
    b = fmul(s[2], s[2]);
    tr = sat(s[0] + s[1]);
    det = sat(a - b);
    t2 = fmul(tr, tr);
    return sat(det - ((t2 >>> 5) + (t2 >>> 7)));
  endfunction

  task automatic check(string req, big_t act, big_t exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edgeCnt, act, exp);
    end
  endtask

  // compare every clock against the reference queues (R6, R8, R10)
  task automatic compareNow();
    bit ev = (expQ.size() > 0) && (expQ[0].due == edgeCnt);
    bit dv = (doneQ.size() > 0) && (doneQ[0].due == edgeCnt);
    check("R6 outValid", big_t'(outValid), big_t'(ev));
    if (ev) begin
      check("R2 outX", big_t'(outX), big_t'(expQ[0].x));
      check("R2 outY", big_t'(outY), big_t'(expQ[0].y));
      check("R3 outR", big_t'(outR), expQ[0].r);
      void'(expQ.pop_front());
    end
    check("R8 frameDone", big_t'(frameDone), big_t'(dv));
    if (dv) begin
      check("R8 frameCount", big_t'(frameCount), big_t'(doneQ[0].n));
      void'(doneQ.pop_front());
    end
  endtask

  task automatic tick(bit v, longint gx, longint gy, int x, int y, bit sof, bit eof);
    @(negedge clk);
    compareNow();
    inValid = v; inGx = GW'(gx); inGy = GW'(gy);
    inX = CW'(x); inY = CW'(y); inSof = sof; inEof = eof;
  endtask

  function automatic longint rnd(longint m);
    return longint'($urandom_range(0, 32'(2*m))) - m;
  endfunction

  // mode 0 small random, 1 full-range random, 2 constant
  task automatic runFrame(big_t thr, int mode, bit gaps, bit midChange, int expCount, string tag);
    frameN = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (mode == 0) begin gxA[y][x] = rnd(1 << 17); gyA[y][x] = rnd(1 << 17); end
        else if (mode == 1) begin gxA[y][x] = rnd((1 << 28) - 1); gyA[y][x] = rnd((1 << 28) - 1); end
        else begin gxA[y][x] = 3 << 15; gyA[y][x] = 1 << 15; end
      end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        bit sof = (x == 0 && y == 0);
        bit eof = (x == W-1 && y == H-1);
        if (gaps && ($urandom_range(0, 2) == 0))
          // R9: idle cycle with live-looking data and markers
          tick(0, rnd(1 << 27), rnd(1 << 27), int'($urandom_range(0, 7)), int'($urandom_range(0, 5)), 1, 1);
        if (sof) begin threshold = thr[42:0]; frameTh = thr; end
        if (midChange && y == 2 && x == 0) threshold = ~thr[42:0]; // R7: ignored until next frame
        tick(1, gxA[y][x], gyA[y][x], x, y, sof, eof);
        if (x >= 2 && y >= 2) begin
          big_t r = modelR(x, y);
          if (r > frameTh) begin
            expQ.push_back('{edgeCnt + 7, x - 1, y - 1, r});
            frameN++;
          end
        end
        if (eof) doneQ.push_back('{edgeCnt + 7, frameN});
      end
    if (expCount >= 0) check(tag, big_t'(frameN), big_t'(expCount));
  endtask

  initial begin
    big_t rc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    check("R10 reset outValid", big_t'(outValid), 0);
    check("R10 reset frameDone", big_t'(frameDone), 0);
    runFrame(0, 0, 0, 0, -1, "");                            // R1 R2 R3
    runFrame(0, 1, 0, 0, -1, "");                            // R4 saturation
    runFrame(-(big_t'(1) <<< 42), 0, 1, 0, -1, "");          // R9 gaps, low threshold
    runFrame((big_t'(1) <<< 42) - 1, 0, 0, 0, 0, "R5 max threshold rejects all");
    runFrame(0, 0, 0, 1, -1, "");                            // R7 mid-frame change
    // constant gradients give one fixed R for every centre
    for (int y = 0; y < H; y++) for (int x = 0; x < W; x++) begin
      gxA[y][x] = 3 << 15; gyA[y][x] = 1 << 15;
    end
    rc = modelR(2, 2);
    runFrame(rc, 2, 0, 0, 0, "R5 threshold equal to R");
    runFrame(rc - 1, 2, 1, 0, (W-2)*(H-2), "R5 threshold one below R");
    runFrame(0, 1, 1, 1, -1, "");                            // R4 R7 R9
    repeat (12) tick(0, 0, 0, 0, 0, 0, 0);
    check("R6 queue drained", big_t'(expQ.size() + doneQ.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule